// File: doc/BRIEF.md
# Serial PHY Management Bus Master

This block is the initiating side of a two-wire management bus used to read and write PHY configuration registers. It derives the management clock from the system clock and turns one command into a complete 64-bit frame: a run of 32 ones, a start code, an operation code, two 5-bit addresses, a 2-bit turnaround and a 16-bit data word. The bidirectional data line is split into a driven value, a drive enable and a sampled input, so the pad can sit outside the block.

A command is taken through a valid/ready handshake. A write is driven onto the line from its first bit to its last. A read drives only the address part. It then releases the line for the turnaround and captures the 16 data bits that the PHY returns. The captured word is offered on a response port until the consumer accepts it. While a frame runs the block reports busy, and it pulses a done strobe for one cycle when the frame ends.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, `mdc`, `mdio_oe`, `busy`, `xfer_done` and `rsp_valid` are 0 and `cmd_ready` is 1.
- R2: Every frame begins with 32 bits of 1 and then the start code 0,1. All of these bits are driven by the master.
- R3: The 2-bit operation code follows the start code. It is 1,0 when `cmd_read`=1 and 0,1 when `cmd_read`=0.
- R4: The 5-bit PHY address and then the 5-bit register address follow the operation code, each sent most significant bit first.
- R5: On a write, the master drives the turnaround as 1 then 0, followed by `cmd_wdata` most significant bit first. `mdio_oe` stays 1 for all 64 bits.
- R6: On a read, `mdio_oe` is 1 for frame bits 0 to 45 and 0 from the first turnaround bit (bit 46) through the last data bit (bit 63).
- R7: On a read, `mdio_i` is sampled as `mdc` rises during bits 48 to 63, and the result is assembled most significant bit first. `rsp_valid` and `rsp_data` hold until `rsp_ready` is seen, and `rsp_valid` clears on the edge where the transfer happens.
- R8: `mdc` toggles every HALF system cycles while busy, where HALF = SYS_CLK_HZ / (2 * MDC_HZ) (25 by default). Within a frame, `mdio_o` and `mdio_oe` change only on edges where `mdc` falls.
- R9: `busy` rises on the edge that accepts a command and falls 128*HALF cycles later, on the last falling edge of `mdc`. `xfer_done` is 1 for exactly that one cycle. While idle, `mdc` and `mdio_oe` are 0.
- R10: `cmd_ready` is 0 while a frame runs and while a read response waits. A command offered then is ignored and does not change the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_read | input | 1 | 1 for a read, 0 for a write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Read data taken |
| rsp_data | output | 16 | Read data |
| busy | output | 1 | Frame in progress |
| xfer_done | output | 1 | One-cycle strobe at the end of a frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value sampled from the data line |

## Verification
Taking the accepting edge as cycle 0, the first rising edge of `mdc` comes at cycle HALF. Bit k rises at (2k+1)*HALF and falls at (2k+2)*HALF. `busy`, `xfer_done` and `rsp_valid` all change at 128*HALF. The bench works at falling system-clock edges only. It records line bits when it sees `mdc` newly high and drives the PHY reply when it sees `mdc` newly low, so each reply bit is settled half a bit period before the design samples it. It counts the falling edges on which `busy` is high and expects exactly 128*HALF of them. Response checks start at the first falling edge after `busy` drops and are repeated while `rsp_ready` is held low.

// File: rtl/mdio_master_pkg.sv
// Shared constants and types for the management bus master.
// Assumes the fixed 64-bit frame layout: 32 ones, start, op, two addresses,
// turnaround, 16 data bits; bit 0 is the first bit on the wire.
package mdio_master_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int DATA_BITS  = 16;
    localparam int ADDR_BITS  = 5;

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mgmt_opc_e;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } mgmt_state_e;

    // Builds the outgoing frame, first wire bit in the top position.
    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic                 rd,
        input logic [ADDR_BITS-1:0] phy,
        input logic [ADDR_BITS-1:0] rg,
        input logic [DATA_BITS-1:0] wd
    );
        mgmt_opc_e opc;
        opc = rd ? OPC_READ : OPC_WRITE;
        return {{32{1'b1}}, 2'b01, opc, phy, rg,
                (rd ? 2'b11 : 2'b10), (rd ? {DATA_BITS{1'b1}} : wd)};
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
// Management clock generator.
// Counts HALF_CYC system cycles per clock phase while run is high and holds
// the clock low otherwise. Tick outputs flag the edge on which mdc will rise
// or fall. Assumes HALF_CYC >= 1.
module mdio_clk_div #(
    parameter int HALF_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] phase_cnt;
    logic          at_end;

    assign at_end    = (phase_cnt == CW'(HALF_CYC - 1));
    assign rise_tick = run && at_end && !mdc;
    assign fall_tick = run && at_end && mdc;

    // Phase counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_cnt <= '0;
            mdc       <= 1'b0;
        end else if (at_end) begin
            phase_cnt <= '0;
            mdc       <= ~mdc;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_tx_shift.sv
// Frame serialiser.
// Loads a whole frame, presents its top bit and shifts left on each advance.
// Also tracks which wire bit is on the line. Assumes load and advance never
// coincide.
module mdio_tx_shift #(
    parameter int W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [W-1:0]         frame_in,
    input  logic                 advance,
    output logic                 bit_out,
    output logic [$clog2(W)-1:0] bit_idx,
    output logic                 last_bit
);
    localparam int IW = $clog2(W);

    logic [W-1:0] sreg;

    assign bit_out  = sreg[W-1];
    assign last_bit = (bit_idx == IW'(W - 1));

    // Shift register and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            bit_idx <= '0;
        end else if (load) begin
            sreg    <= frame_in;
            bit_idx <= '0;
        end else if (advance) begin
            sreg    <= {sreg[W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_capture.sv
// Read data deserialiser.
// Shifts the sampled line value in from the bottom on each sample strobe.
// Assumes the owner stops strobing while the captured word is being held.
module mdio_rx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] word
);
    // Sample shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)      word <= '0;
        else if (sample) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
// Management bus master top.
// Accepts one command at a time and runs a full frame. On reads it releases
// the line from the turnaround onward and captures the reply as mdc rises.
// The line changes only as mdc falls. Assumes SYS_CLK_HZ >= 2 * MDC_HZ; the
// divider is clamped to one cycle per phase otherwise.
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int SYS_CLK_HZ = 125_000_000,
    parameter int MDC_HZ     = 2_500_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_read,
    input  logic [ADDR_BITS-1:0] cmd_phy,
    input  logic [ADDR_BITS-1:0] cmd_reg,
    input  logic [DATA_BITS-1:0] cmd_wdata,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [DATA_BITS-1:0] rsp_data,
    output logic                 busy,
    output logic                 xfer_done,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);
    localparam int RAW_HALF = SYS_CLK_HZ / (2 * MDC_HZ);
    localparam int HALF_CYC = (RAW_HALF < 1) ? 1 : RAW_HALF;
    localparam int IW       = $clog2(FRAME_BITS);
    localparam logic [IW:0]   TA_LIM   = (IW+1)'(TA_POS);
    localparam logic [IW-1:0] DATA_LIM = IW'(DATA_POS);

    mgmt_state_e     state;
    logic            rd_q;
    logic            oe_q;
    logic            done_q;
    logic            rsp_valid_q;
    logic            accept;
    logic            rise_tick;
    logic            fall_tick;
    logic            tx_bit;
    logic [IW-1:0]   tx_idx;
    logic            tx_last;
    logic            rx_sample;
    logic [IW:0]     next_idx;
    logic [FRAME_BITS-1:0] frame_word;

    assign busy      = (state == MS_RUN);
    assign cmd_ready = (state == MS_IDLE) && !rsp_valid_q;
    assign accept    = cmd_valid && cmd_ready;
    assign rsp_valid = rsp_valid_q;
    assign xfer_done = done_q;
    assign mdio_oe   = oe_q;
    assign mdio_o    = tx_bit;
    assign next_idx  = {1'b0, tx_idx} + 1'b1;
    assign rx_sample = rise_tick && rd_q && (tx_idx >= DATA_LIM);
    assign frame_word = make_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);

    mdio_clk_div #(.HALF_CYC(HALF_CYC)) i_clk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_tx_shift #(.W(FRAME_BITS)) i_tx_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .frame_in (frame_word),
        .advance  (fall_tick && !tx_last),
        .bit_out  (tx_bit),
        .bit_idx  (tx_idx),
        .last_bit (tx_last)
    );

    mdio_rx_capture #(.W(DATA_BITS)) i_rx_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rx_sample),
        .din    (mdio_i),
        .word   (rsp_data)
    );

    // Frame sequencing: start on accept, stop after the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MS_IDLE;
            rd_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state <= MS_RUN;
                rd_q  <= cmd_read;
            end else if (fall_tick && tx_last) begin
                state  <= MS_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    // Line direction: drive from the start, release for a read turnaround or at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (accept) begin
            oe_q <= 1'b1;
        end else if (fall_tick) begin
            if (tx_last)                        oe_q <= 1'b0;
            else if (rd_q && next_idx >= TA_LIM) oe_q <= 1'b0;
        end
    end

    // Read response: raise at the end of a read, hold until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rsp_valid_q <= 1'b0;
        else if (fall_tick && tx_last && rd_q) rsp_valid_q <= 1'b1;
        else if (rsp_valid_q && rsp_ready)   rsp_valid_q <= 1'b0;
    end
endmodule

// File: rtl/mdio_master_checker.sv
// Protocol checker for the management bus master, bound to every instance.
// Watches the ports plus the latched operation and the current wire bit.
module mdio_master_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        cmd_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [15:0] rsp_data,
    input logic        xfer_done,
    input logic        rd_q,
    input logic [5:0]  bit_idx
);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!busy && $past(busy)));

    assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);

    assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    assert_line_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (!$stable(mdio_o) || !$stable(mdio_oe))) |-> $fell(mdc));

    assert_write_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_q) |-> mdio_oe);

    assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_q && bit_idx >= 6'd46) |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_checker i_mdio_master_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .xfer_done (xfer_done),
    .rd_q      (rd_q),
    .bit_idx   (tx_idx)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
    localparam int SYS_HZ = 125_000_000;
    localparam int MGT_HZ = 2_500_000;
    localparam int HALF   = SYS_HZ / (2 * MGT_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_data;
    logic        busy;
    logic        xfer_done;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mdio_master #(.SYS_CLK_HZ(SYS_HZ), .MDC_HZ(MGT_HZ)) i_mdio_master (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .busy(busy), .xfer_done(xfer_done),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected 64-bit wire pattern, first bit at the top.
    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
    endfunction

    task automatic run_xfer(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [15:0] phy_word, input int hold);
        logic [63:0] cap_o;
        logic [63:0] cap_oe;
        logic [63:0] ef;
        int nrise = 0;
        int cyc = 0;
        int last_tog = 0;
        bit have_tog = 0;
        int bad_per = 0;
        int bad_chg = 0;
        int bad_rdy = 0;
        int nbusy = 0;
        bit p_mdc, p_o, p_oe;
        cap_o = '0;
        cap_oe = '0;
        ef = exp_frame(rd, phy, rg, wd);
        mdio_i = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        // R10: offer a conflicting command while the frame runs
        cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
        p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
        while (busy) begin
            nbusy++;
            if (cmd_ready) bad_rdy++;
            if (nbusy == 10 * HALF) cmd_valid = 1'b0;
            @(negedge clk);
            cyc++;
            if (mdc != p_mdc) begin
                if (have_tog && (cyc - last_tog) != HALF) bad_per++;
                have_tog = 1;
                last_tog = cyc;
            end
            if (mdc && !p_mdc && nrise < 64) begin
                cap_o[63 - nrise]  = mdio_o;
                cap_oe[63 - nrise] = mdio_oe;
                nrise++;
            end
            if ((mdio_oe != p_oe || (mdio_oe && mdio_o != p_o)) && !(!mdc && p_mdc))
                bad_chg++;
            if (!mdc && p_mdc && rd) begin
                if (nrise == 46)                   mdio_i = 1'b1;
                else if (nrise == 47)              mdio_i = 1'b0;
                else if (nrise >= 48 && nrise < 64) mdio_i = phy_word[63 - nrise];
                else                               mdio_i = 1'b1;
            end
            p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
        end
        cmd_valid = 1'b0;
        check(nbusy == 128 * HALF, "R9 busy length", 64'(nbusy), 64'(128 * HALF));
        check(xfer_done == 1'b1 && !mdc && !mdio_oe, "R9 end state",
              {61'd0, xfer_done, mdc, mdio_oe}, 64'd4);
        check(bad_rdy == 0, "R10 ready during frame", 64'(bad_rdy), 64'd0);
        check(bad_per == 0 && bad_chg == 0, "R8 clock period and change edges",
              {32'(bad_per), 32'(bad_chg)}, 64'd0);
        check(nrise == 64 && cap_o[63:30] == ef[63:30] && (&cap_oe[63:30]),
              "R2 preamble and start", {cap_o[63:30], 30'd0}, {ef[63:30], 30'd0});
        check(cap_o[29:28] == ef[29:28], "R3 opcode", 64'(cap_o[29:28]), 64'(ef[29:28]));
        check(cap_o[27:18] == ef[27:18], "R4 addresses", 64'(cap_o[27:18]), 64'(ef[27:18]));
        if (!rd) begin
            check(cap_o[17:0] == ef[17:0] && (&cap_oe), "R5 write tail",
                  {cap_oe[31:0], 14'd0, cap_o[17:0]}, {32'hFFFF_FFFF, 14'd0, ef[17:0]});
            check(!rsp_valid, "R7 no response on write", 64'(rsp_valid), 64'd0);
        end else begin
            check(cap_oe == {{46{1'b1}}, 18'd0}, "R6 read release", cap_oe, {{46{1'b1}}, 18'd0});
            for (int i = 0; i <= hold; i++) begin
                check(rsp_valid && rsp_data == phy_word && !cmd_ready, "R7 read data held",
                      {46'd0, rsp_valid, cmd_ready, rsp_data}, {46'd0, 2'b10, phy_word});
                if (i < hold) @(negedge clk);
            end
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            check(!rsp_valid && cmd_ready, "R7 response released",
                  {62'd0, rsp_valid, cmd_ready}, 64'd1);
        end
        @(negedge clk);
    endtask

    initial begin
        #(8ns * 150000);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4211));
        repeat (4) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !xfer_done && !rsp_valid && cmd_ready, "R1 reset state",
              {58'd0, mdc, mdio_oe, busy, xfer_done, rsp_valid, cmd_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mdc && !mdio_oe && cmd_ready, "R1 after release",
              {61'd0, mdc, mdio_oe, cmd_ready}, 64'd1);
        // directed corners
        run_xfer(1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, 0);
        run_xfer(1'b1, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 3);
        run_xfer(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 0);
        run_xfer(1'b1, 5'd0,  5'd0,  16'hFFFF, 16'h0000, 0);
        run_xfer(1'b1, 5'd21, 5'd10, 16'h1234, 16'h8001, 1);
        run_xfer(1'b0, 5'd10, 5'd21, 16'hA5C3, 16'h0000, 0);
        // random mix
        for (int n = 0; n < 12; n++) begin
            run_xfer(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                     16'($urandom), int'($urandom % 5));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule